// File: doc/BRIEF.md
# Multi-Bank Clock Divider

This block turns one fast source clock into three banks of divided clocks and one feedback clock. Each bank and the feedback path has its own even division ratio, picked from a small table by static select pins. A shared prescale stage either passes the source straight to the dividers or lets them advance only on every second source cycle. Two outputs of the third bank can be inverted as a group. The whole block runs in the source clock domain: every divided clock is a register output, and the prescale is a clock enable, not a generated clock.

All configuration inputs are captured while the synchronous active-low reset is held and are frozen after it is released. On the first source edge after release, every divider starts together, so all outputs rise on the same edge. Each clock output has a valid flag beside it. The flag stands in for an output enable: it is low with the outputs held low during reset, and it is high once the block is running.

Top module: `clk_bank_divider`

## Requirements
- R1: Bank A has a period of 4, 6, 8 or 12 ticks for `sel_a` codes 00, 01, 10 and 11.
- R2: Bank B has a period of 4, 6, 8 or 10 ticks for `sel_b` codes 00, 01, 10 and 11.
- R3: Bank C has a period of 2, 4, 6 or 8 ticks for `sel_c` codes 00, 01, 10 and 11.
- R4: The feedback clock has a period of 4, 6, 8, 10, 8, 12, 16 or 20 ticks for `sel_fb` codes 000 through 111, in that order.
- R5: A tick is one source cycle when `prescale_direct` is 1, and two source cycles when it is 0.
- R6: Every divided clock is high for exactly half its period and low for the other half. The high half comes first after release.
- R7: When `inv_c` is 1, bank C outputs 2 and 3 are the complement of outputs 0 and 1 while valid. When `inv_c` is 0, all four bank C outputs are equal. All outputs within a bank are otherwise identical.
- R8: One source edge after `rst_n` is sampled low, every clock output is 0 and every valid flag is 0. This also holds when reset is applied mid-run.
- R9: On the first source edge with `rst_n` high, all valid flags rise together and every non-inverted output goes high. The valid flags then stay high until the next reset.
- R10: The select, prescale and inversion inputs are captured only while reset is held. Changes made while running have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast source clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; captures configuration |
| prescale_direct | input | 1 | 1: tick every source cycle; 0: tick every second cycle |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select |
| inv_c | input | 1 | Inverts bank C outputs 2 and 3 when 1 |
| bank_a | output | NUM_A | Bank A clocks |
| bank_b | output | NUM_B | Bank B clocks |
| bank_c | output | NUM_C | Bank C clocks |
| fb_clk | output | 1 | Feedback clock |
| a_valid | output | 1 | Bank A outputs enabled |
| b_valid | output | 1 | Bank B outputs enabled |
| c_valid | output | 1 | Bank C outputs enabled |
| fb_valid | output | 1 | Feedback output enabled |

## Verification
The reset state is due one source edge after reset is sampled low. The bench drives inputs on falling edges and reads the outputs on the following falling edge, half a cycle after the register update. After release, the first falling edge is sample 0, where every non-inverted output must already be high. From that sample, the bench expects the first falling transition at index ratio×prescale/2 and the next rising transition at index ratio×prescale. Because each output is a single register, these indices follow directly from the tick count with no added pipeline latency.

// File: rtl/clkdiv_pkg.sv
// Shared width and ratio tables for the multi-bank clock divider.
// Assumes every ratio in the tables is even and below 2**RATIO_W.
package clkdiv_pkg;

    localparam int RATIO_W = 5;

    typedef logic [RATIO_W-1:0] ratio_t;

    // Maps the bank A select code to its division ratio.
    function automatic ratio_t ratio_bank_a(input logic [1:0] code);
        case (code)
            2'd0:    return ratio_t'(4);
            2'd1:    return ratio_t'(6);
            2'd2:    return ratio_t'(8);
            default: return ratio_t'(12);
        endcase
    endfunction

    // Maps the bank B select code to its division ratio.
    function automatic ratio_t ratio_bank_b(input logic [1:0] code);
        case (code)
            2'd0:    return ratio_t'(4);
            2'd1:    return ratio_t'(6);
            2'd2:    return ratio_t'(8);
            default: return ratio_t'(10);
        endcase
    endfunction

    // Maps the bank C select code to its division ratio.
    function automatic ratio_t ratio_bank_c(input logic [1:0] code);
        return ratio_t'({code, 1'b0} + 3'd2);
    endfunction

    // Maps the feedback select code to its division ratio.
    function automatic ratio_t ratio_fb(input logic [2:0] code);
        case (code)
            3'd0:    return ratio_t'(4);
            3'd1:    return ratio_t'(6);
            3'd2:    return ratio_t'(8);
            3'd3:    return ratio_t'(10);
            3'd4:    return ratio_t'(8);
            3'd5:    return ratio_t'(12);
            3'd6:    return ratio_t'(16);
            default: return ratio_t'(20);
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_cfg.sv
// Configuration capture: loads selects, prescale and inversion while reset
// is held and converts the select codes to ratios.
// Assumes the configuration inputs are stable during the reset pulse.
module clkdiv_cfg
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       direct_in,
    input  logic [1:0] sel_a,
    input  logic [1:0] sel_b,
    input  logic [1:0] sel_c,
    input  logic [2:0] sel_fb,
    input  logic       inv_in,
    output logic       direct_q,
    output logic       inv_q,
    output ratio_t     ratio_a,
    output ratio_t     ratio_b,
    output ratio_t     ratio_c,
    output ratio_t     ratio_f
);

    // Capture during reset; hold the captured values while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            direct_q <= direct_in;
            inv_q    <= inv_in;
            ratio_a  <= ratio_bank_a(sel_a);
            ratio_b  <= ratio_bank_b(sel_b);
            ratio_c  <= ratio_bank_c(sel_c);
            ratio_f  <= ratio_fb(sel_fb);
        end
    end

endmodule

// File: rtl/clkdiv_prescale.sv
// Prescale enable: produces a tick every source cycle (direct) or every
// second cycle. The first running cycle always ticks.
// Assumes direct is static while running.
module clkdiv_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic direct,
    output logic tick
);

    logic phase;

    // Alternate the phase; preset so the first running cycle ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b1;
        else        phase <= ~phase;
    end

    // A tick occurs on every cycle in direct mode, on odd phases otherwise.
    always_comb tick = direct | phase;

endmodule

// File: rtl/clkdiv_even.sv
// Even-ratio divider with a 50% duty cycle, counting prescale ticks.
// Its output is high for ratio/2 ticks starting at the first running edge.
// Assumes ratio is even, at least 2, and static while running.
module clkdiv_even #(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [RW-1:0] ratio,
    output logic          clk_o,
    output logic          valid_o
);

    logic [RW-1:0] cnt;
    logic [RW-1:0] half;
    logic          wrap;

    // Half-period threshold and end-of-period detection.
    always_comb begin
        half = ratio >> 1;
        wrap = (cnt == ratio - RW'(1));
    end

    // Advance the phase counter and update the output on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            clk_o   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b1;
            if (tick) begin
                clk_o <= (cnt < half);
                cnt   <= wrap ? '0 : cnt + RW'(1);
            end
        end
    end

endmodule

// File: rtl/clk_bank_divider.sv
// Top level: three clock banks and a feedback clock divided from one source
// clock. Bank C outputs at index INV_LO and above can be inverted.
// Assumes configuration is applied under reset; everything runs on src_clk.
module clk_bank_divider
    import clkdiv_pkg::*;
#(
    parameter int NUM_A  = 4,
    parameter int NUM_B  = 4,
    parameter int NUM_C  = 4,
    parameter int INV_LO = 2
) (
    input  logic             src_clk,
    input  logic             rst_n,
    input  logic             prescale_direct,
    input  logic [1:0]       sel_a,
    input  logic [1:0]       sel_b,
    input  logic [1:0]       sel_c,
    input  logic [2:0]       sel_fb,
    input  logic             inv_c,
    output logic [NUM_A-1:0] bank_a,
    output logic [NUM_B-1:0] bank_b,
    output logic [NUM_C-1:0] bank_c,
    output logic             fb_clk,
    output logic             a_valid,
    output logic             b_valid,
    output logic             c_valid,
    output logic             fb_valid
);

    localparam int NDIV = 4;

    logic   direct_q, inv_q, tick;
    ratio_t ratio_a, ratio_b, ratio_c, ratio_f;
    ratio_t ratio_v [NDIV];
    logic   div_clk [NDIV];
    logic   div_vld [NDIV];

    clkdiv_cfg u_cfg (
        .clk      (src_clk),
        .rst_n    (rst_n),
        .direct_in(prescale_direct),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .sel_c    (sel_c),
        .sel_fb   (sel_fb),
        .inv_in   (inv_c),
        .direct_q (direct_q),
        .inv_q    (inv_q),
        .ratio_a  (ratio_a),
        .ratio_b  (ratio_b),
        .ratio_c  (ratio_c),
        .ratio_f  (ratio_f)
    );

    clkdiv_prescale u_pre (
        .clk   (src_clk),
        .rst_n (rst_n),
        .direct(direct_q),
        .tick  (tick)
    );

    // Gather the captured ratios into one array for the divider loop.
    always_comb begin
        ratio_v[0] = ratio_a;
        ratio_v[1] = ratio_b;
        ratio_v[2] = ratio_c;
        ratio_v[3] = ratio_f;
    end

    for (genvar d = 0; d < NDIV; d++) begin : g_div
        clkdiv_even #(.RW(RATIO_W)) u_div (
            .clk    (src_clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .ratio  (ratio_v[d]),
            .clk_o  (div_clk[d]),
            .valid_o(div_vld[d])
        );
    end

    for (genvar i = 0; i < NUM_A; i++) begin : g_fan_a
        assign bank_a[i] = div_clk[0];
    end

    for (genvar i = 0; i < NUM_B; i++) begin : g_fan_b
        assign bank_b[i] = div_clk[1];
    end

    for (genvar i = 0; i < NUM_C; i++) begin : g_fan_c
        if (i >= INV_LO) begin : g_inv
            assign bank_c[i] = div_vld[2] & (div_clk[2] ^ inv_q);
        end else begin : g_true
            assign bank_c[i] = div_clk[2];
        end
    end

    assign fb_clk   = div_clk[3];
    assign a_valid  = div_vld[0];
    assign b_valid  = div_vld[1];
    assign c_valid  = div_vld[2];
    assign fb_valid = div_vld[3];

endmodule

// File: rtl/clk_bank_divider_chk.sv
// Checker for clk_bank_divider: reset state, valid behaviour, aligned start
// and fixed bank C inversion. Attached to every instance by bind.
module clk_bank_divider_chk #(
    parameter int NUM_A  = 4,
    parameter int NUM_B  = 4,
    parameter int NUM_C  = 4,
    parameter int INV_LO = 2
) (
    input logic             src_clk,
    input logic             rst_n,
    input logic [NUM_A-1:0] bank_a,
    input logic [NUM_B-1:0] bank_b,
    input logic [NUM_C-1:0] bank_c,
    input logic             fb_clk,
    input logic             a_valid,
    input logic             b_valid,
    input logic             c_valid,
    input logic             fb_valid
);

    logic rst_low_d = 1'b0;

    // Remember whether reset was sampled low at the previous edge.
    always_ff @(posedge src_clk) rst_low_d <= !rst_n;

    // R8: one edge after reset, all outputs and flags are low.
    always @(posedge src_clk) begin
        if (rst_low_d) begin
            assert_reset_clears_R8: assert (!a_valid && !b_valid && !c_valid && !fb_valid
                && bank_a == '0 && bank_b == '0 && bank_c == '0 && !fb_clk)
                else $error("reset state violated");
        end
    end

    assert_valid_holds_R9: assert property (@(posedge src_clk) disable iff (!rst_n)
        a_valid |=> a_valid);

    assert_valid_match_R9: assert property (@(posedge src_clk) disable iff (!rst_n)
        (a_valid == b_valid) && (a_valid == c_valid) && (a_valid == fb_valid));

    assert_aligned_start_R9: assert property (@(posedge src_clk) disable iff (!rst_n)
        $rose(a_valid) |-> (bank_a[0] && bank_b[0] && bank_c[0] && fb_clk));

    // R7: the relation between inverted and true bank C outputs never changes.
    assert_inv_constant_R7: assert property (@(posedge src_clk) disable iff (!rst_n)
        (c_valid && $past(c_valid)) |-> $stable(bank_c[NUM_C-1] ^ bank_c[0]));

endmodule

bind clk_bank_divider clk_bank_divider_chk #(
    .NUM_A(NUM_A), .NUM_B(NUM_B), .NUM_C(NUM_C), .INV_LO(INV_LO)
) chk (
    .src_clk (src_clk),
    .rst_n   (rst_n),
    .bank_a  (bank_a),
    .bank_b  (bank_b),
    .bank_c  (bank_c),
    .fb_clk  (fb_clk),
    .a_valid (a_valid),
    .b_valid (b_valid),
    .c_valid (c_valid),
    .fb_valid(fb_valid)
);

// File: tb/clk_bank_divider_test.sv
`timescale 1ns/1ps
module clk_bank_divider_test;

    localparam int CAP = 96;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre = 1'b0;
    logic [1:0] sa = '0, sb = '0, sc = '0;
    logic [2:0] sfb = '0;
    logic       inv = 1'b0;
    logic [3:0] bank_a, bank_b, bank_c;
    logic       fb_clk, a_valid, b_valid, c_valid, fb_valid;

    int checks = 0;
    int errors = 0;
    logic smp [4][CAP];
    int   fan_bad;

    typedef struct packed {
        logic        pre;
        logic [1:0]  sa;
        logic [1:0]  sb;
        logic [1:0]  sc;
        logic [2:0]  sfb;
        logic        inv;
        int unsigned ra;
        int unsigned rb;
        int unsigned rc;
        int unsigned rf;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{1'b0, 2'd0, 2'd0, 2'd0, 3'd0, 1'b0, 4,  4,  2, 4},
        '{1'b0, 2'd1, 2'd1, 2'd1, 3'd1, 1'b1, 6,  6,  4, 6},
        '{1'b0, 2'd2, 2'd2, 2'd2, 3'd2, 1'b0, 8,  8,  6, 8},
        '{1'b0, 2'd3, 2'd3, 2'd3, 3'd3, 1'b1, 12, 10, 8, 10},
        '{1'b0, 2'd0, 2'd0, 2'd0, 3'd4, 1'b0, 4,  4,  2, 8},
        '{1'b0, 2'd1, 2'd1, 2'd1, 3'd5, 1'b1, 6,  6,  4, 12},
        '{1'b0, 2'd2, 2'd2, 2'd2, 3'd6, 1'b0, 8,  8,  6, 16},
        '{1'b0, 2'd3, 2'd3, 2'd3, 3'd7, 1'b1, 12, 10, 8, 20},
        '{1'b1, 2'd0, 2'd0, 2'd0, 3'd0, 1'b1, 4,  4,  2, 4},
        '{1'b1, 2'd1, 2'd1, 2'd1, 3'd1, 1'b0, 6,  6,  4, 6},
        '{1'b1, 2'd2, 2'd2, 2'd2, 3'd2, 1'b1, 8,  8,  6, 8},
        '{1'b1, 2'd3, 2'd3, 2'd3, 3'd3, 1'b0, 12, 10, 8, 10},
        '{1'b1, 2'd0, 2'd0, 2'd0, 3'd4, 1'b1, 4,  4,  2, 8},
        '{1'b1, 2'd1, 2'd1, 2'd1, 3'd5, 1'b0, 6,  6,  4, 12},
        '{1'b1, 2'd2, 2'd2, 2'd2, 3'd6, 1'b1, 8,  8,  6, 16},
        '{1'b1, 2'd3, 2'd3, 2'd3, 3'd7, 1'b0, 12, 10, 8, 20}
    };

    clk_bank_divider uut (
        .src_clk(clk), .rst_n(rst_n), .prescale_direct(pre),
        .sel_a(sa), .sel_b(sb), .sel_c(sc), .sel_fb(sfb), .inv_c(inv),
        .bank_a(bank_a), .bank_b(bank_b), .bank_c(bank_c), .fb_clk(fb_clk),
        .a_valid(a_valid), .b_valid(b_valid), .c_valid(c_valid), .fb_valid(fb_valid)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_reset_state(input string req);
        check(req, "valid flags", {a_valid, b_valid, c_valid, fb_valid}, 0);
        check(req, "clock outputs", {bank_a, bank_b, bank_c, fb_clk}, 0);
    endtask

    // Apply a configuration under reset and check the reset state (R8).
    task automatic enter_reset(input vec_t v);
        @(negedge clk);
        rst_n = 1'b0; pre = v.pre; sa = v.sa; sb = v.sb; sc = v.sc;
        sfb = v.sfb; inv = v.inv;
        @(negedge clk);
        @(negedge clk);
        check_reset_state("R8");
    endtask

    // Release reset and record samples; optionally scramble the inputs (R10).
    task automatic release_capture(input bit scramble, input logic inv_exp);
        rst_n = 1'b1;
        fan_bad = 0;
        for (int k = 0; k < CAP; k++) begin
            @(negedge clk);
            smp[0][k] = bank_a[0];
            smp[1][k] = bank_b[0];
            smp[2][k] = bank_c[0];
            smp[3][k] = fb_clk;
            if (bank_a != {4{bank_a[0]}} || bank_b != {4{bank_b[0]}}
                || bank_c[1] != bank_c[0] || bank_c[3:2] != {2{bank_c[0] ^ inv_exp}}
                || !a_valid || !b_valid || !c_valid || !fb_valid)
                fan_bad++;
            if (scramble && k == 2) begin
                pre = ~pre; sa = ~sa; sb = ~sb; sc = ~sc; sfb = ~sfb; inv = ~inv;
            end
        end
    endtask

    // Check start level, high length and period of one recorded channel.
    task automatic check_chan(input int ch, input string req, input int ratio, input logic direct);
        int half, fall, rise;
        half = direct ? ratio / 2 : ratio;
        fall = -1; rise = -1;
        for (int k = 1; k < CAP; k++) begin
            if (fall < 0 && !smp[ch][k]) fall = k;
            else if (fall >= 0 && rise < 0 && smp[ch][k]) rise = k;
        end
        check("R9", "starts high", int'(smp[ch][0]), 1);
        check("R6", "high length", fall, half);
        check(req, "period (R5 tick scale)", rise, 2 * half);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Reset state from power-up.
        @(negedge clk);
        @(negedge clk);
        check_reset_state("R8");

        // Table walk: every select code in both prescale modes (R1..R7).
        foreach (VECS[i]) begin
            enter_reset(VECS[i]);
            release_capture(1'b0, VECS[i].inv);
            check_chan(0, "R1", int'(VECS[i].ra), VECS[i].pre);
            check_chan(1, "R2", int'(VECS[i].rb), VECS[i].pre);
            check_chan(2, "R3", int'(VECS[i].rc), VECS[i].pre);
            check_chan(3, "R4", int'(VECS[i].rf), VECS[i].pre);
            check("R7", "fanout/inversion/valid mismatches", fan_bad, 0);
        end

        // R10: inputs changed while running are ignored.
        enter_reset(VECS[8]);
        release_capture(1'b1, VECS[8].inv);
        check_chan(0, "R10", 4, 1'b1);
        check_chan(3, "R10", 4, 1'b1);
        check("R10", "inversion unchanged", fan_bad, 0);

        // R10: the scrambled inputs take effect at the next reset.
        enter_reset(VECS[7]);
        release_capture(1'b0, VECS[7].inv);
        check_chan(0, "R10", 12, 1'b0);
        check_chan(3, "R10", 20, 1'b0);

        // R8: mid-run reset clears everything after one edge.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R8");

        // R3 boundary: the shortest ratio in direct mode toggles every cycle.
        enter_reset(VECS[12]);
        release_capture(1'b0, VECS[12].inv);
        check("R3", "c toggles at sample 1", int'(smp[2][1]), 0);
        check("R3", "c high again at sample 2", int'(smp[2][2]), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule